// File: doc/BRIEF.md
# Per-Port Audio Event Interrupt Bank

This block turns per-port audio stream events into a single interrupt line. It has five sources, each a sticky register with one bit per port. Source 0 records output FIFO underruns and source 1 records ring-buffer underruns. Source 2 records ring-buffer overruns, source 3 records free-space threshold crossings and source 4 records fill-level threshold crossings. Sources 0, 1 and 3 belong to the playback side. Each of them has `PLAY_PORTS` bits: three serial audio outputs and one digital audio transmitter. Sources 2 and 4 belong to the capture side. Each of them has `CAP_PORTS` bits, one for each serial audio input. Bit n of any source belongs to port n.

A status bit records its event whether or not it is masked. Software reads the status and masks without side effects and clears status bits by writing ones to them. Every source has a per-port mask, and a mask bit of 1 disables that port. Each source drives one bit of a five-bit summary word. That bit latches while the source has a status bit that is set and not masked. The summary has its own mask and a write-one acknowledge. The interrupt output is the OR of the summary bits that are not masked. All writes arrive as one indexed strobe that carries an operation code, a source index and a data word.

Top module: `port_event_irq_bank`

## Requirements
- R1: After reset, every status bit and summary bit is 0 and the interrupt is low. Every implemented mask bit and all five summary mask bits are 1.
- R2: An event pulse sets its status bit at the next clock edge, whatever the mask holds. The bit then stays set until a status-clear write clears it.
- R3: A status-clear write (op 0) to source k clears exactly the bits of source k where the data word holds a 1. All other bits and sources keep their values.
- R4: When an event and a status-clear hit the same bit at the same edge, the bit ends up set.
- R5: A mask-set write (op 1) sets the selected mask bits of source k to 1. A mask-clear write (op 2) clears them to 0. All other mask bits keep their values.
- R6: Summary bit k becomes 1 one edge after source k holds a status bit that is set and not masked. It then stays 1 until it is acknowledged.
- R7: A summary acknowledge (op 5, data bit k) clears summary bit k only if source k no longer has a pending unmasked bit. Otherwise the bit stays set.
- R8: Summary mask-set (op 3) and mask-clear (op 4) act on data bits 4..0 and ignore the source index. The interrupt is high in the same cycle in which any summary bit is 1 with its summary mask at 0.
- R9: A status bit that is masked never sets its summary bit. Clearing its mask bit while the status bit is still set raises the summary bit one edge later.
- R10: Sources 2 and 4 implement only bits 0..`CAP_PORTS`-1. Their upper status and mask bits always read 0, and events or writes aimed at those bits have no effect.
- R11: A per-source write with a source index above 4, or any write with op 6 or 7, changes no status, mask or summary bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 5*SLOT_W | Event pulses, source k in slot [k*SLOT_W +: SLOT_W], bit n = port n |
| wr_valid_i | input | 1 | Write strobe |
| wr_op_i | input | 3 | Operation: 0 status clear, 1 mask set, 2 mask clear, 3 summary mask set, 4 summary mask clear, 5 summary acknowledge |
| wr_reg_i | input | 3 | Source index 0..4 for ops 0..2 |
| wr_data_i | input | DATA_W | Write-one data bits |
| stat_o | output | 5*SLOT_W | Status of every source, same slot layout as evt_i |
| mask_o | output | 5*SLOT_W | Mask of every source, 1 = disabled |
| top_stat_o | output | 5 | Summary status, bit k = source k |
| top_mask_o | output | 5 | Summary mask, 1 = disabled |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check four things: a status bit stays set unless it is cleared, an event beats a clear on the same bit, mask writes land, and a summary bit rises only when its source is pending and then holds until a valid acknowledge. They also check that the interrupt is never high without a summary bit set. Some behaviour can only be shown by the bench scenarios. These include the exact reset values, that a clear or mask write reaches only the chosen source, and the one-edge lag between unmasking a latched bit and the summary rising. The same applies to the narrow capture sources reading zero in their upper bits and to writes with an invalid op or index leaving every output unchanged.

// File: rtl/pev_pkg.sv
package pev_pkg;

   localparam int unsigned NUM_SRC = 5;

   typedef enum logic [2:0] {
      OP_STAT_CLR = 3'd0,
      OP_MASK_SET = 3'd1,
      OP_MASK_CLR = 3'd2,
      OP_TOP_MSET = 3'd3,
      OP_TOP_MCLR = 3'd4,
      OP_TOP_ACK  = 3'd5
   } pev_op_e;

   // capture-side sources carry the narrower port count
   function automatic bit src_is_capture(input int unsigned idx);
      return (idx == 2) || (idx == 4);
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned slot_width(input int unsigned play, input int unsigned cap);
      return max2(play, cap);
   endfunction

   function automatic int unsigned data_width(input int unsigned play, input int unsigned cap);
      return max2(slot_width(play, cap), NUM_SRC);
   endfunction

endpackage

// File: rtl/pev_status_bank.sv
module pev_status_bank #(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] evt_i,
   input  logic [WIDTH-1:0] clr_i,
   input  logic [WIDTH-1:0] mset_i,
   input  logic [WIDTH-1:0] mclr_i,
   output logic [WIDTH-1:0] stat_o,
   output logic [WIDTH-1:0] mask_o,
   output logic             pend_o
);

   logic [WIDTH-1:0] stat_q;
   logic [WIDTH-1:0] mask_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stat_q <= '0;
         mask_q <= '1;
      end else begin
         stat_q <= (stat_q & ~clr_i) | evt_i;
         mask_q <= (mask_q & ~mclr_i) | mset_i;
      end
   end

   assign stat_o = stat_q;
   assign mask_o = mask_q;
   assign pend_o = |(stat_q & ~mask_q);

   // R2: a set status bit survives every edge without a clear on it
   p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((stat_q & $past(stat_q & ~clr_i)) == $past(stat_q & ~clr_i)));

   // R4: an event always lands, even against a clear
   p_event_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

   // R5: mask set lands, mask clear lands
   p_mask_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((mask_q & $past(mset_i)) == $past(mset_i)));
   p_mask_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((mask_q & $past(mclr_i & ~mset_i)) == '0));

endmodule

// File: rtl/pev_summary.sv
module pev_summary #(
   parameter int unsigned N = 5
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] pend_i,
   input  logic [N-1:0] ack_i,
   input  logic [N-1:0] mset_i,
   input  logic [N-1:0] mclr_i,
   output logic [N-1:0] top_stat_o,
   output logic [N-1:0] top_mask_o,
   output logic         irq_o
);

   logic [N-1:0] top_q;
   logic [N-1:0] tmask_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         top_q   <= '0;
         tmask_q <= '1;
      end else begin
         top_q   <= (top_q & ~ack_i) | pend_i;
         tmask_q <= (tmask_q & ~mclr_i) | mset_i;
      end
   end

   assign top_stat_o = top_q;
   assign top_mask_o = tmask_q;
   assign irq_o      = |(top_q & ~tmask_q);

   // R6: a pending source is reflected one edge later
   p_top_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((top_q & $past(pend_i)) == $past(pend_i)));

   // R7: a summary bit only falls when acknowledged
   p_top_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((top_q & $past(top_q & ~ack_i)) == $past(top_q & ~ack_i)));

   // R9: a summary bit only rises from a pending source
   p_top_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (((top_q & ~$past(top_q)) & ~$past(pend_i)) == '0));

   // R8: the interrupt needs a summary bit behind it
   p_irq_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (top_q != '0));

endmodule

// File: rtl/port_event_irq_bank.sv
module port_event_irq_bank
   import pev_pkg::*;
#(
   parameter int unsigned PLAY_PORTS = 4,
   parameter int unsigned CAP_PORTS  = 3
) (
   input  logic                                                   clk_i,
   input  logic                                                   rst_ni,
   input  logic [NUM_SRC*slot_width(PLAY_PORTS, CAP_PORTS)-1:0]   evt_i,
   input  logic                                                   wr_valid_i,
   input  logic [2:0]                                             wr_op_i,
   input  logic [2:0]                                             wr_reg_i,
   input  logic [data_width(PLAY_PORTS, CAP_PORTS)-1:0]           wr_data_i,
   output logic [NUM_SRC*slot_width(PLAY_PORTS, CAP_PORTS)-1:0]   stat_o,
   output logic [NUM_SRC*slot_width(PLAY_PORTS, CAP_PORTS)-1:0]   mask_o,
   output logic [NUM_SRC-1:0]                                     top_stat_o,
   output logic [NUM_SRC-1:0]                                     top_mask_o,
   output logic                                                   irq_o
);

   localparam int unsigned SLOT_W = slot_width(PLAY_PORTS, CAP_PORTS);
   localparam int unsigned DATA_W = data_width(PLAY_PORTS, CAP_PORTS);

   if (PLAY_PORTS < 1 || CAP_PORTS < 1) begin : g_bad_ports
      $error("port counts must be at least one");
   end
   if (PLAY_PORTS > 31 || CAP_PORTS > 31) begin : g_bad_width
      $error("port counts must fit a status word");
   end

   // write decode
   logic                 op_stat_clr, op_mask_set, op_mask_clr;
   logic                 op_top_mset, op_top_mclr, op_top_ack;
   logic [NUM_SRC-1:0]   src_hit;
   logic [NUM_SRC-1:0]   pend;
   logic [NUM_SRC-1:0]   top_data;

   always_comb begin
      op_stat_clr = wr_valid_i && (wr_op_i == OP_STAT_CLR);
      op_mask_set = wr_valid_i && (wr_op_i == OP_MASK_SET);
      op_mask_clr = wr_valid_i && (wr_op_i == OP_MASK_CLR);
      op_top_mset = wr_valid_i && (wr_op_i == OP_TOP_MSET);
      op_top_mclr = wr_valid_i && (wr_op_i == OP_TOP_MCLR);
      op_top_ack  = wr_valid_i && (wr_op_i == OP_TOP_ACK);
      for (int k = 0; k < NUM_SRC; k++) begin
         src_hit[k] = (wr_reg_i == 3'(k));
      end
      top_data = wr_data_i[NUM_SRC-1:0];
   end

   for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
      localparam int unsigned BW = src_is_capture(k) ? CAP_PORTS : PLAY_PORTS;

      logic [BW-1:0] b_clr, b_mset, b_mclr, b_stat, b_mask;

      assign b_clr  = (op_stat_clr && src_hit[k]) ? wr_data_i[BW-1:0] : '0;
      assign b_mset = (op_mask_set && src_hit[k]) ? wr_data_i[BW-1:0] : '0;
      assign b_mclr = (op_mask_clr && src_hit[k]) ? wr_data_i[BW-1:0] : '0;

      pev_status_bank #(.WIDTH(BW)) u_bank (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .evt_i  (evt_i[k*SLOT_W +: BW]),
         .clr_i  (b_clr),
         .mset_i (b_mset),
         .mclr_i (b_mclr),
         .stat_o (b_stat),
         .mask_o (b_mask),
         .pend_o (pend[k])
      );

      if (BW < SLOT_W) begin : g_pad
         logic unused_evt_hi;
         assign unused_evt_hi = ^evt_i[k*SLOT_W + BW +: SLOT_W - BW];
         assign stat_o[k*SLOT_W +: SLOT_W] = {{(SLOT_W-BW){1'b0}}, b_stat};
         assign mask_o[k*SLOT_W +: SLOT_W] = {{(SLOT_W-BW){1'b0}}, b_mask};
      end else begin : g_full
         assign stat_o[k*SLOT_W +: SLOT_W] = b_stat;
         assign mask_o[k*SLOT_W +: SLOT_W] = b_mask;
      end
   end

   if (DATA_W > NUM_SRC) begin : g_data_sink
      logic unused_data_hi;
      assign unused_data_hi = ^wr_data_i[DATA_W-1:NUM_SRC];
   end

   pev_summary #(.N(NUM_SRC)) u_summary (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pend_i     (pend),
      .ack_i      (op_top_ack  ? top_data : '0),
      .mset_i     (op_top_mset ? top_data : '0),
      .mclr_i     (op_top_mclr ? top_data : '0),
      .top_stat_o (top_stat_o),
      .top_mask_o (top_mask_o),
      .irq_o      (irq_o)
   );

   // R11: an invalid op never moves the summary mask
   p_bad_op_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_valid_i && wr_op_i > 3'd5) |=> $stable(top_mask_o));

endmodule

// File: tb/port_event_irq_bank_bench.sv
`timescale 1ns/1ps
module port_event_irq_bank_bench;

   localparam int SW = 4;

   logic          clk_i = 1'b0;
   logic          rst_ni = 1'b0;
   logic [19:0]   evt_i = '0;
   logic          wr_valid_i = 1'b0;
   logic [2:0]    wr_op_i = '0;
   logic [2:0]    wr_reg_i = '0;
   logic [4:0]    wr_data_i = '0;
   logic [19:0]   stat_o, mask_o;
   logic [4:0]    top_stat_o, top_mask_o;
   logic          irq_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #2 clk_i = ~clk_i;

   port_event_irq_bank u_port_event_irq_bank (
      .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i),
      .wr_valid_i(wr_valid_i), .wr_op_i(wr_op_i), .wr_reg_i(wr_reg_i),
      .wr_data_i(wr_data_i), .stat_o(stat_o), .mask_o(mask_o),
      .top_stat_o(top_stat_o), .top_mask_o(top_mask_o), .irq_o(irq_o)
   );

   function automatic logic [3:0] slot(input logic [19:0] bus, input int k);
      return bus[k*SW +: SW];
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk_i);
   endtask

   task automatic do_reset();
      rst_ni = 1'b0; evt_i = '0; wr_valid_i = 1'b0;
      repeat (2) tick();
      rst_ni = 1'b1;
      tick();
   endtask

   task automatic wr(input logic [2:0] op, input logic [2:0] rg, input logic [4:0] d);
      wr_valid_i = 1'b1; wr_op_i = op; wr_reg_i = rg; wr_data_i = d;
      tick();
      wr_valid_i = 1'b0;
   endtask

   task automatic pulse(input int k, input logic [3:0] bits);
      evt_i[k*SW +: SW] = bits;
      tick();
      evt_i = '0;
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 stat", stat_o, 20'h0);
      check("R1 mask", mask_o, 20'h7F7FF);
      check("R1 top_mask", top_mask_o, 5'h1F);
      check("R1 top_stat", top_stat_o, 5'h0);
      check("R1 irq", irq_o, 1'b0);
   endtask

   task automatic t_masked_latch_and_irq();
      do_reset();
      pulse(0, 4'b0100);
      check("R2 latch while masked", slot(stat_o, 0), 4'h4);
      tick(); tick();
      check("R2 still set", slot(stat_o, 0), 4'h4);
      check("R9 masked no summary", top_stat_o, 5'h0);
      wr(3'd2, 3'd0, 5'h04);
      check("R5 mask clear", slot(mask_o, 0), 4'hB);
      check("R9 not yet", top_stat_o, 5'h0);
      tick();
      check("R9 summary after unmask", top_stat_o, 5'h01);
      check("R8 irq masked at top", irq_o, 1'b0);
      wr(3'd4, 3'd7, 5'h01);
      check("R8 top mask clear", top_mask_o, 5'h1E);
      check("R8 irq high", irq_o, 1'b1);
      wr(3'd5, 3'd0, 5'h01);
      check("R7 ack while pending", top_stat_o, 5'h01);
      wr(3'd0, 3'd0, 5'h04);
      check("R3 status cleared", slot(stat_o, 0), 4'h0);
      tick();
      check("R6 sticky after source clear", top_stat_o, 5'h01);
      wr(3'd5, 3'd0, 5'h01);
      check("R7 ack clears", top_stat_o, 5'h00);
      check("R8 irq low", irq_o, 1'b0);
      wr(3'd3, 3'd0, 5'h01);
      check("R8 top mask set", top_mask_o, 5'h1F);
   endtask

   task automatic t_clear_and_race();
      do_reset();
      pulse(3, 4'b1001);
      pulse(1, 4'b0010);
      wr(3'd0, 3'd3, 5'h01);
      check("R3 selective clear", slot(stat_o, 3), 4'h8);
      check("R3 other source kept", slot(stat_o, 1), 4'h2);
      evt_i[1*SW +: SW] = 4'b0010;
      wr(3'd0, 3'd1, 5'h02);
      evt_i = '0;
      check("R4 event beats clear", slot(stat_o, 1), 4'h2);
      wr(3'd0, 3'd1, 5'h02);
      check("R3 plain clear", slot(stat_o, 1), 4'h0);
      check("R3 source 3 kept", slot(stat_o, 3), 4'h8);
   endtask

   task automatic t_mask_ops();
      do_reset();
      wr(3'd2, 3'd3, 5'h05);
      check("R5 clear bits", slot(mask_o, 3), 4'hA);
      check("R5 neighbour kept", slot(mask_o, 1), 4'hF);
      wr(3'd1, 3'd3, 5'h01);
      check("R5 set bit", slot(mask_o, 3), 4'hB);
   endtask

   task automatic t_capture_width();
      do_reset();
      pulse(2, 4'hF);
      check("R10 capture status width", slot(stat_o, 2), 4'h7);
      wr(3'd2, 3'd4, 5'h0F);
      check("R10 capture mask clear", slot(mask_o, 4), 4'h0);
      wr(3'd1, 3'd4, 5'h0F);
      check("R10 capture mask set", slot(mask_o, 4), 4'h7);
      wr(3'd0, 3'd2, 5'h08);
      check("R10 upper clear ignored", slot(stat_o, 2), 4'h7);
   endtask

   task automatic t_bad_writes();
      logic [19:0] s0, m0;
      do_reset();
      pulse(4, 4'h1);
      wr(3'd2, 3'd4, 5'h01);
      tick();
      s0 = stat_o; m0 = mask_o;
      for (int rg = 5; rg < 8; rg++) begin
         for (int op = 0; op < 3; op++) wr(3'(op), 3'(rg), 5'h1F);
      end
      wr(3'd6, 3'd0, 5'h1F);
      wr(3'd7, 3'd4, 5'h1F);
      tick();
      check("R11 stat unchanged", stat_o, s0);
      check("R11 mask unchanged", mask_o, m0);
      check("R11 top stat unchanged", top_stat_o, 5'h10);
      check("R11 top mask unchanged", top_mask_o, 5'h1F);
   endtask

   initial begin
      t_reset();
      t_masked_latch_and_irq();
      t_clear_and_race();
      t_mask_ops();
      t_capture_width();
      t_bad_writes();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk_i);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

endmodule